// File: doc/BRIEF.md
# Split-Storage SECDED Codec for Tag Identifiers

This block guards an identifier read from tag memory against bits that flip while stored. It uses an extended Hamming code over a 128-bit code word: up to 120 payload bits, seven Hamming parity bits and one overall parity bit. The code corrects any single flipped bit and flags any two flipped bits. The payload and the 8 check bits enter and leave on separate ports. This lets the identifier keep its original encoding in its own field while the check bits sit in another memory area, so checking becomes an optional step on the read side.

The encoder path takes a payload and returns the 8 check bits to store. The decoder path takes the payload and check bits as read back. It returns the repaired payload, the repaired check bits (ready to be written back), the 7-bit syndrome, and one of three status flags: clean, corrected or uncorrectable. Both paths are valid-qualified, with one register stage. A payload narrower than 120 bits is zero-padded in its upper code positions on both sides, and those zeros still take part in the parity equations.

Top module: `tagecc_codec`

## Requirements
- R1: Code word layout. Check bit k+1 (k = 0..6) is the parity at code position 2^k, covering every position whose index has bit k set. Payload bit i fills the i-th position, counted upward, among positions 1..127 that are not powers of two. Check bit 0 sits at position 0 and makes the parity of all 128 positions even.
- R2: `enc_valid_o` and `enc_check_o` present, one clock after `enc_valid_i` is high, the check bits of the payload accepted on that edge. `enc_valid_o` is low one clock after a cycle with `enc_valid_i` low.
- R3: With `PAY_W` below 120, the code positions for payload bits PAY_W..119 hold zero on both the encoder and the decoder side. The check bits therefore equal those of the payload zero-extended to 120 bits.
- R4: A word read back with no flipped bit gives `dec_clean_o` high, a syndrome of 0, and the payload and check bits unchanged.
- R5: A word with exactly one flipped payload bit gives `dec_fixed_o` high, a syndrome equal to that bit's code position, and the original payload and check bits.
- R6: A word with exactly one flipped check bit gives `dec_fixed_o` high and the original payload and check bits. The syndrome is 2^(j-1) for check bit j ≥ 1, and 0 for check bit 0.
- R7: A word with exactly two flipped bits gives `dec_fatal_o` high, a syndrome equal to the XOR of the two code positions, and the payload and check bits exactly as read, with no correction.
- R8: Whenever `dec_valid_o` is high, exactly one of `dec_clean_o`, `dec_fixed_o` and `dec_fatal_o` is high. Whenever `dec_valid_o` is low, all three are low.
- R9: While reset is asserted, and after it until the first accepted input, both output valids, all flags and all data, check and syndrome outputs read zero.
- R10: `dec_valid_o` is high exactly one clock after a cycle with `dec_valid_i` high, and its outputs describe the word accepted on that edge.
- R11: Single-bit correction works for a stored 1 read as 0 and for a stored 0 read as 1 alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Encoder payload valid |
| enc_data_i | input | PAY_W | Payload to protect |
| enc_valid_o | output | 1 | Encoder result valid |
| enc_check_o | output | HAM_P+1 | Check bits to store in the separate area |
| dec_valid_i | input | 1 | Decoder input valid |
| dec_data_i | input | PAY_W | Payload as read back |
| dec_check_i | input | HAM_P+1 | Check bits as read back |
| dec_valid_o | output | 1 | Decoder result valid |
| dec_data_o | output | PAY_W | Repaired payload |
| dec_check_o | output | HAM_P+1 | Repaired check bits |
| dec_syndrome_o | output | HAM_P | Hamming syndrome of the word read |
| dec_clean_o | output | 1 | No error found |
| dec_fixed_o | output | 1 | One bit corrected |
| dec_fatal_o | output | 1 | Two bits flipped, nothing corrected |

## Verification
The bench targets a flip of the overall parity bit, where the syndrome is zero. A design that classified by syndrome alone would call this word clean and return a wrong check bit 0. Double flips that include a check bit get the same attention: a design that corrected whatever the syndrome points at would damage a good payload bit instead of flagging the word. A second instance with a 96-bit payload probes the padding. If the padded positions were left out of the parity equations, or shifted the position map, the check bits would differ from those of the zero-extended payload. Single flips are drawn at random over every code position and in both directions, so a wrong entry in the position map shows up as a wrong syndrome or a wrong repaired bit.

// File: rtl/tagecc_pkg.sv
package tagecc_pkg;

   // True when p is a power of two (a Hamming parity position).
   function automatic bit is_pow2(input int p);
      return (p > 0) && ((p & (p - 1)) == 0);
   endfunction

   // Code position of payload bit idx in a word of cw positions.
   function automatic int data_pos(input int idx, input int cw);
      int n;
      int r;
      n = 0;
      r = 0;
      for (int p = 1; p < cw; p++) begin
         if (!is_pow2(p)) begin
            if (n == idx) r = p;
            n++;
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/tagecc_scatter.sv
// Places payload and check bits at their code word positions.
module tagecc_scatter #(
   parameter int HAM_P = 7,
   parameter int PAY_W = 120
) (
   input  logic [PAY_W-1:0]   data_i,
   input  logic [HAM_P:0]     check_i,
   output logic [(1<<HAM_P)-1:0] word_o
);
   localparam int CW   = 1 << HAM_P;
   localparam int DMAX = CW - 1 - HAM_P;

   assign word_o[0] = check_i[0];

   for (genvar k = 0; k < HAM_P; k++) begin : g_par
      assign word_o[1 << k] = check_i[k+1];
   end

   for (genvar i = 0; i < DMAX; i++) begin : g_dat
      localparam int P = tagecc_pkg::data_pos(i, CW);
      if (i < PAY_W) begin : g_live
         assign word_o[P] = data_i[i];
      end else begin : g_pad
         assign word_o[P] = 1'b0;
      end
   end
endmodule

// File: rtl/tagecc_gather.sv
// Pulls payload and check bits back out of a code word.
module tagecc_gather #(
   parameter int HAM_P = 7,
   parameter int PAY_W = 120
) (
   input  logic [(1<<HAM_P)-1:0] word_i,
   output logic [PAY_W-1:0]   data_o,
   output logic [HAM_P:0]     check_o
);
   localparam int CW = 1 << HAM_P;

   assign check_o[0] = word_i[0];

   for (genvar k = 0; k < HAM_P; k++) begin : g_par
      assign check_o[k+1] = word_i[1 << k];
   end

   for (genvar i = 0; i < PAY_W; i++) begin : g_dat
      localparam int P = tagecc_pkg::data_pos(i, CW);
      assign data_o[i] = word_i[P];
   end
endmodule

// File: rtl/tagecc_syndrome.sv
// Syndrome = XOR of the indices of all set positions; parity = XOR of all bits.
module tagecc_syndrome #(
   parameter int HAM_P = 7
) (
   input  logic [(1<<HAM_P)-1:0] word_i,
   output logic [HAM_P-1:0]   syn_o,
   output logic               parity_o
);
   localparam int CW = 1 << HAM_P;

   always_comb begin
      syn_o = '0;
      for (int p = 1; p < CW; p++) begin
         if (word_i[p]) syn_o = syn_o ^ HAM_P'(p);
      end
   end

   assign parity_o = ^word_i;
endmodule

// File: rtl/tagecc_encoder.sv
// Combinational check-bit generator.
module tagecc_encoder #(
   parameter int HAM_P = 7,
   parameter int PAY_W = 120
) (
   input  logic [PAY_W-1:0] data_i,
   output logic [HAM_P:0]   check_o
);
   localparam int CW = 1 << HAM_P;

   logic [CW-1:0]    word;
   logic [HAM_P-1:0] syn;
   logic             dpar;

   tagecc_scatter #(.HAM_P(HAM_P), .PAY_W(PAY_W)) scat_i (
      .data_i  (data_i),
      .check_i ('0),
      .word_o  (word)
   );

   tagecc_syndrome #(.HAM_P(HAM_P)) syn_i (
      .word_i   (word),
      .syn_o    (syn),
      .parity_o (dpar)
   );

   // Parity bits cancel the payload syndrome; bit 0 evens the whole word.
   assign check_o = {syn, dpar ^ (^syn)};
endmodule

// File: rtl/tagecc_decoder.sv
// Combinational classifier and single-bit repair.
module tagecc_decoder #(
   parameter int HAM_P = 7,
   parameter int PAY_W = 120
) (
   input  logic [PAY_W-1:0] data_i,
   input  logic [HAM_P:0]   check_i,
   output logic [PAY_W-1:0] data_o,
   output logic [HAM_P:0]   check_o,
   output logic [HAM_P-1:0] syn_o,
   output logic             clean_o,
   output logic             fixed_o,
   output logic             fatal_o
);
   localparam int CW = 1 << HAM_P;

   logic [CW-1:0]    word;
   logic [CW-1:0]    fixw;
   logic [HAM_P-1:0] syn;
   logic             par;

   tagecc_scatter #(.HAM_P(HAM_P), .PAY_W(PAY_W)) scat_i (
      .data_i  (data_i),
      .check_i (check_i),
      .word_o  (word)
   );

   tagecc_syndrome #(.HAM_P(HAM_P)) syn_i (
      .word_i   (word),
      .syn_o    (syn),
      .parity_o (par)
   );

   // Odd overall parity means one flip; a zero syndrome then names position 0.
   always_comb begin
      fixw = word;
      if (par) fixw[syn] = ~word[syn];
   end

   tagecc_gather #(.HAM_P(HAM_P), .PAY_W(PAY_W)) gath_i (
      .word_i  (fixw),
      .data_o  (data_o),
      .check_o (check_o)
   );

   assign syn_o   = syn;
   assign fixed_o = par;
   assign clean_o = !par && (syn == '0);
   assign fatal_o = !par && (syn != '0);
endmodule

// File: rtl/tagecc_codec.sv
// Registered encoder and decoder paths for split-storage SECDED.
module tagecc_codec #(
   parameter int HAM_P = 7,
   parameter int PAY_W = 120
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enc_valid_i,
   input  logic [PAY_W-1:0]   enc_data_i,
   output logic               enc_valid_o,
   output logic [HAM_P:0]     enc_check_o,
   input  logic               dec_valid_i,
   input  logic [PAY_W-1:0]   dec_data_i,
   input  logic [HAM_P:0]     dec_check_i,
   output logic               dec_valid_o,
   output logic [PAY_W-1:0]   dec_data_o,
   output logic [HAM_P:0]     dec_check_o,
   output logic [HAM_P-1:0]   dec_syndrome_o,
   output logic               dec_clean_o,
   output logic               dec_fixed_o,
   output logic               dec_fatal_o
);
   localparam int CW   = 1 << HAM_P;
   localparam int DMAX = CW - 1 - HAM_P;

   if (HAM_P < 3 || HAM_P > 8) begin : g_bad_hamp
      $error("tagecc_codec: HAM_P must lie in 3..8");
   end
   if (PAY_W < 1 || PAY_W > DMAX) begin : g_bad_payw
      $error("tagecc_codec: PAY_W must lie in 1..(2**HAM_P-1-HAM_P)");
   end

   logic [HAM_P:0]   enc_chk_c;
   logic [PAY_W-1:0] dec_data_c;
   logic [HAM_P:0]   dec_chk_c;
   logic [HAM_P-1:0] dec_syn_c;
   logic             dec_cl_c, dec_fx_c, dec_ft_c;

   tagecc_encoder #(.HAM_P(HAM_P), .PAY_W(PAY_W)) enc_i (
      .data_i  (enc_data_i),
      .check_o (enc_chk_c)
   );

   tagecc_decoder #(.HAM_P(HAM_P), .PAY_W(PAY_W)) dec_i (
      .data_i  (dec_data_i),
      .check_i (dec_check_i),
      .data_o  (dec_data_c),
      .check_o (dec_chk_c),
      .syn_o   (dec_syn_c),
      .clean_o (dec_cl_c),
      .fixed_o (dec_fx_c),
      .fatal_o (dec_ft_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enc_valid_o <= 1'b0;
         enc_check_o <= '0;
      end else begin
         enc_valid_o <= enc_valid_i;
         if (enc_valid_i) enc_check_o <= enc_chk_c;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid_o    <= 1'b0;
         dec_data_o     <= '0;
         dec_check_o    <= '0;
         dec_syndrome_o <= '0;
         dec_clean_o    <= 1'b0;
         dec_fixed_o    <= 1'b0;
         dec_fatal_o    <= 1'b0;
      end else begin
         dec_valid_o <= dec_valid_i;
         dec_clean_o <= dec_valid_i & dec_cl_c;
         dec_fixed_o <= dec_valid_i & dec_fx_c;
         dec_fatal_o <= dec_valid_i & dec_ft_c;
         if (dec_valid_i) begin
            dec_data_o     <= dec_data_c;
            dec_check_o    <= dec_chk_c;
            dec_syndrome_o <= dec_syn_c;
         end
      end
   end
endmodule

// File: rtl/tagecc_chk.sv
// Property checker attached to tagecc_codec.
module tagecc_chk #(
   parameter int HAM_P = 7,
   parameter int PAY_W = 120
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enc_valid_i,
   input logic             enc_valid_o,
   input logic             dec_valid_i,
   input logic [PAY_W-1:0] dec_data_i,
   input logic [HAM_P:0]   dec_check_i,
   input logic             dec_valid_o,
   input logic [PAY_W-1:0] dec_data_o,
   input logic [HAM_P:0]   dec_check_o,
   input logic [HAM_P-1:0] dec_syndrome_o,
   input logic             dec_clean_o,
   input logic             dec_fixed_o,
   input logic             dec_fatal_o
);
   AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      enc_valid_i |=> enc_valid_o);                                          // R2
   AST_ENC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !enc_valid_i |=> !enc_valid_o);                                        // R2
   AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid_i |=> dec_valid_o);                                          // R10
   AST_DEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid_i |=> !dec_valid_o);                                        // R10
   AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid_o |-> $countones({dec_clean_o, dec_fixed_o, dec_fatal_o}) == 1); // R8
   AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid_o |-> !(dec_clean_o || dec_fixed_o || dec_fatal_o));        // R8
   AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      dec_clean_o |-> (dec_syndrome_o == '0) && (dec_data_o == $past(dec_data_i))
                      && (dec_check_o == $past(dec_check_i)));               // R4
   AST_FATAL_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      dec_fatal_o |-> (dec_syndrome_o != '0) && (dec_data_o == $past(dec_data_i))
                      && (dec_check_o == $past(dec_check_i)));               // R7
   AST_FIX_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      dec_fixed_o |-> $countones({dec_data_o ^ $past(dec_data_i),
                                  dec_check_o ^ $past(dec_check_i)}) <= 1);  // R5
endmodule

bind tagecc_codec tagecc_chk #(.HAM_P(HAM_P), .PAY_W(PAY_W)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .enc_valid_i    (enc_valid_i),
   .enc_valid_o    (enc_valid_o),
   .dec_valid_i    (dec_valid_i),
   .dec_data_i     (dec_data_i),
   .dec_check_i    (dec_check_i),
   .dec_valid_o    (dec_valid_o),
   .dec_data_o     (dec_data_o),
   .dec_check_o    (dec_check_o),
   .dec_syndrome_o (dec_syndrome_o),
   .dec_clean_o    (dec_clean_o),
   .dec_fixed_o    (dec_fixed_o),
   .dec_fatal_o    (dec_fatal_o)
);

// File: tb/tagecc_codec_tb_top.sv
module tagecc_codec_tb_top;
   localparam int WN    = 96;
   localparam int NCYC  = 3000;

   typedef struct {
      bit           v;
      logic [119:0] d;
      logic [7:0]   c;
      logic [6:0]   s;
      bit           cl, fx, ft;
      string        tag;
   } exp_t;

   logic clk = 1'b0;
   always #5 clk = ~clk;
   logic rst_n;

   // wide instance
   logic         ew_vi, ew_vo;
   logic [119:0] ew_d;
   logic [7:0]   ew_c;
   logic         dw_vi, dw_vo;
   logic [119:0] dw_d, dw_do;
   logic [7:0]   dw_ci, dw_co;
   logic [6:0]   dw_s;
   logic         dw_cl, dw_fx, dw_ft;
   // narrow instance
   logic         en_vi, en_vo;
   logic [WN-1:0] en_d;
   logic [7:0]   en_c;
   logic         dn_vi, dn_vo;
   logic [WN-1:0] dn_d, dn_do;
   logic [7:0]   dn_ci, dn_co;
   logic [6:0]   dn_s;
   logic         dn_cl, dn_fx, dn_ft;

   tagecc_codec #(.HAM_P(7), .PAY_W(120)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .enc_valid_i(ew_vi), .enc_data_i(ew_d), .enc_valid_o(ew_vo), .enc_check_o(ew_c),
      .dec_valid_i(dw_vi), .dec_data_i(dw_d), .dec_check_i(dw_ci),
      .dec_valid_o(dw_vo), .dec_data_o(dw_do), .dec_check_o(dw_co),
      .dec_syndrome_o(dw_s), .dec_clean_o(dw_cl), .dec_fixed_o(dw_fx), .dec_fatal_o(dw_ft));

   tagecc_codec #(.HAM_P(7), .PAY_W(WN)) dut_n_i (
      .clk(clk), .rst_n(rst_n),
      .enc_valid_i(en_vi), .enc_data_i(en_d), .enc_valid_o(en_vo), .enc_check_o(en_c),
      .dec_valid_i(dn_vi), .dec_data_i(dn_d), .dec_check_i(dn_ci),
      .dec_valid_o(dn_vo), .dec_data_o(dn_do), .dec_check_o(dn_co),
      .dec_syndrome_o(dn_s), .dec_clean_o(dn_cl), .dec_fixed_o(dn_fx), .dec_fatal_o(dn_ft));

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;
   int pos_tbl [120];

   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Reference encoder: accumulate code positions of set payload bits.
   function automatic logic [7:0] ref_enc(input logic [119:0] d);
      logic [6:0] acc = '0;
      bit ones = 0;
      for (int i = 0; i < 120; i++) begin
         if (d[i]) begin
            acc  = acc ^ 7'(pos_tbl[i]);
            ones = !ones;
         end
      end
      return {acc, ones ^ (^acc)};
   endfunction

   // Slot 0..7 is a check bit, slot 8+ is payload bit slot-8.
   function automatic int slot_pos(input int sl);
      if (sl == 0) return 0;
      if (sl < 8)  return 1 << (sl - 1);
      return pos_tbl[sl - 8];
   endfunction

   task automatic flip_slot(input int sl, inout logic [119:0] d, inout logic [7:0] c);
      if (sl < 8) c[sl] = ~c[sl];
      else        d[sl-8] = ~d[sl-8];
   endtask

   task automatic make_case(input int width, input int mode, input logic [119:0] raw,
                            output logic [119:0] dd, output logic [7:0] cd, output exp_t e);
      logic [119:0] d;
      logic [7:0] c;
      int r1, r2;
      d = raw;
      for (int i = width; i < 120; i++) d[i] = 1'b0;
      c = ref_enc(d);
      dd = d; cd = c;
      e.v = (mode != 0); e.d = d; e.c = c; e.s = '0;
      e.cl = 1; e.fx = 0; e.ft = 0; e.tag = "R4";
      if (mode == 2) begin
         r1 = 8 + $urandom_range(width - 1);
         e.tag = d[r1-8] ? "R5/R11 1to0" : "R5/R11 0to1";
         flip_slot(r1, dd, cd);
         e.s = 7'(slot_pos(r1)); e.cl = 0; e.fx = 1;
      end else if (mode == 3) begin
         r1 = $urandom_range(7);
         e.tag = "R6";
         flip_slot(r1, dd, cd);
         e.s = 7'(slot_pos(r1)); e.cl = 0; e.fx = 1;
      end else if (mode == 4) begin
         r1 = $urandom_range(width + 7);
         r2 = r1;
         while (r2 == r1) r2 = $urandom_range(width + 7);
         flip_slot(r1, dd, cd);
         flip_slot(r2, dd, cd);
         e.tag = "R7";
         e.d = dd; e.c = cd;
         e.s = 7'(slot_pos(r1) ^ slot_pos(r2)); e.cl = 0; e.ft = 1;
      end
      if (width < 120) e.tag = {e.tag, " R3"};
   endtask

   task automatic cmp_dec(input exp_t e, input int width, input logic vo,
                          input logic [119:0] dout, input logic [7:0] cout,
                          input logic [6:0] s, input logic cl, input logic fx, input logic ft);
      logic [119:0] m;
      m = '0;
      for (int i = 0; i < width; i++) m[i] = 1'b1;
      chk("R10", "dec valid", 128'(vo), 128'(e.v));
      if (e.v) begin
         chk(e.tag, "dec data", 128'(dout & m), 128'(e.d & m));
         chk(e.tag, "dec check", 128'(cout), 128'(e.c));
         chk(e.tag, "dec syndrome", 128'(s), 128'(e.s));
         chk({e.tag, " R8"}, "dec flags", 128'({cl, fx, ft}), 128'({e.cl, e.fx, e.ft}));
      end else begin
         chk("R8", "idle flags", 128'({cl, fx, ft}), 128'(0));
      end
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(2_000_000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hang expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      exp_t ew, en, nw, nn;
      logic [127:0] rnd;
      logic [119:0] ed_prev, ed_n_prev;
      logic [119:0] tmp_d;
      logic [7:0]   tmp_c;
      bit ev_prev, ev_n_prev;
      int mode, k;

      k = 0;
      for (int p = 1; p < 128; p++) begin
         if ((p & (p - 1)) != 0) begin
            pos_tbl[k] = p;
            k++;
         end
      end

      rst_n = 1'b0;
      ew_vi = 0; ew_d = '0; dw_vi = 0; dw_d = '0; dw_ci = '0;
      en_vi = 0; en_d = '0; dn_vi = 0; dn_d = '0; dn_ci = '0;
      repeat (3) @(negedge clk);
      // R9: reset state at the ports of both instances
      chk("R9", "reset valids", 128'({ew_vo, dw_vo, en_vo, dn_vo}), 128'(0));
      chk("R9", "reset flags", 128'({dw_cl, dw_fx, dw_ft, dn_cl, dn_fx, dn_ft}), 128'(0));
      chk("R9", "reset data", 128'(dw_do), 128'(0));
      chk("R9", "reset check/syn", 128'({ew_c, dw_co, dw_s, en_c, dn_co, dn_s}), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "post-reset outputs", 128'({ew_vo, dw_vo, dw_cl, dw_fx, dw_ft, dw_s, dw_co}), 128'(0));

      ev_prev = 0; ev_n_prev = 0; ed_prev = '0; ed_n_prev = '0;
      ew.v = 0; ew.tag = "R8"; en.v = 0; en.tag = "R8";
      for (int cyc = 0; cyc < NCYC; cyc++) begin
         if (cyc > 0) begin
            chk("R2", "enc valid", 128'(ew_vo), 128'(ev_prev));
            if (ev_prev) chk("R1/R2", "enc check", 128'(ew_c), 128'(ref_enc(ed_prev)));
            chk("R2", "narrow enc valid", 128'(en_vo), 128'(ev_n_prev));
            if (ev_n_prev) chk("R3", "narrow enc check", 128'(en_c), 128'(ref_enc(ed_n_prev)));
            cmp_dec(ew, 120, dw_vo, dw_do, dw_co, dw_s, dw_cl, dw_fx, dw_ft);
            cmp_dec(en, WN, dn_vo, 120'(dn_do), dn_co, dn_s, dn_cl, dn_fx, dn_ft);
         end
         // encoder stimulus
         rnd = {$urandom, $urandom, $urandom, $urandom};
         ew_vi = ($urandom_range(9) != 0);
         ew_d  = rnd[119:0];
         en_vi = ($urandom_range(9) != 0);
         en_d  = rnd[WN+7:8];
         ev_prev = ew_vi; ed_prev = ew_d;
         ev_n_prev = en_vi; ed_n_prev = 120'(en_d);
         // decoder stimulus: 0 idle, 1 clean, 2 payload flip, 3 check flip, 4 double
         k = $urandom_range(99);
         mode = (k < 10) ? 0 : (k < 30) ? 1 : (k < 60) ? 2 : (k < 75) ? 3 : 4;
         rnd = {$urandom, $urandom, $urandom, $urandom};
         make_case(120, mode, rnd[119:0], tmp_d, tmp_c, nw);
         dw_vi = nw.v; dw_d = tmp_d; dw_ci = tmp_c;
         k = $urandom_range(99);
         mode = (k < 10) ? 0 : (k < 30) ? 1 : (k < 60) ? 2 : (k < 75) ? 3 : 4;
         rnd = {$urandom, $urandom, $urandom, $urandom};
         make_case(WN, mode, rnd[119:0], tmp_d, tmp_c, nn);
         dn_vi = nn.v; dn_d = tmp_d[WN-1:0]; dn_ci = tmp_c;
         ew = nw; en = nn;
         @(negedge clk);
      end
      done = 1;
      summary();
      $finish;
   end
endmodule